// File: doc/BRIEF.md
# Programmable Odd-Ratio Clock Divider

This block derives a slower clock from a fast master clock. A 4-bit ratio code selects the divide factor N. The low two code bits pick a base ratio, and the high two bits scale that base by a power of two. A build-time parameter selects one of two base tables. Odd N is supported. For odd N, a stage clocked on the falling edge of the master clock trims the high phase by half a master cycle, so the high phase and the low phase each last exactly N/2 master cycles.

A new ratio code, and a new value of the phase-invert input, are taken only when an output period starts. A change therefore never shortens a pulse that is already under way. Two inputs can park the output low: `enable` driven to 0, or the active-low `stop_n` request. In both cases the output completes its current high phase and then stays low. When the channel is released, it restarts at the beginning of a period with a full-width first phase. No data flows through the block, so all of its pins are plain control or clock signals.

Top module: `oddiv_top`

## Requirements
- R1: While `rst_n` is low, and after its release until the channel first starts, `clk_out` is 0.
- R2: With `TABLE_B`=0, `div_code[1:0]` selects base 00=2, 01=3, 10=5, 11=7. `div_code[3:2]` multiplies the base by 00=1, 01=2, 10=4, 11=8. Each high phase and each low phase of `clk_out` lasts N/2 master cycles.
- R3: With `TABLE_B`=1, the base values are 00=4, 01=3, 10=5, 11=9, with the same multiplier. This gives N from 3 to 72.
- R4: For odd N, the high phase ends on a falling edge of the master clock, so high and low each last exactly N/2 cycles.
- R5: A new `div_code` is adopted only at the next period start. The period under way completes at the old ratio.
- R6: `stop_n` is synchronized. A stop is recognized only once it has been sampled low on two consecutive rising edges. A single low sample has no effect.
- R7: When a stop is recognized, or `enable` is 0, the channel halts at the next high-to-low transition of `clk_out`. The final high pulse keeps its full width, and `clk_out` then stays 0.
- R8: When `enable` is 1 and no stop is pending, a halted channel restarts at a period start. Its first high and low phases are full width.
- R9: When `invert`=1, the divided waveform is inverted, and the value is taken at period start. On restart, the inverted output begins with its low phase. When halted, the output is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 4 | Ratio code: [1:0] base select, [3:2] power-of-two multiplier |
| invert | input | 1 | 1 inverts the divided clock |
| enable | input | 1 | 1 = active, 0 = output held low |
| stop_n | input | 1 | Active-low stop request, asynchronous to the channel |
| clk_out | output | 1 | Divided clock |

## Verification
The bench measures every high and low run of the output at half-master-cycle resolution. Odd ratios are checked to exactly N half-cycles, so a design without the falling-edge trim shows a run one half-cycle too long or too short.

A code change made mid-pulse must leave that pulse and its low phase at the old width. A design that loads the code immediately would emit a runt pulse. A one-cycle low pulse on `stop_n` must be ignored, while a real stop must leave a full final pulse followed by silence. Restarts are timed from the release. A design that skips inversion on restart, or that does not realign its counter, starts at the wrong level or with a short first phase.

// File: rtl/oddiv_pkg.sv
`timescale 1ns/1ps
package oddiv_pkg;
  localparam int CODE_W  = 4;
  localparam int RATIO_W = 7;
  typedef logic [RATIO_W-1:0] ratio_t;

  // ratio code loaded at reset (base 3, times 2 in the first table)
  localparam logic [CODE_W-1:0] CODE_DEFAULT = 4'b0101;

  function automatic logic [3:0] base_a(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd2;
      2'b01:   return 4'd3;
      2'b10:   return 4'd5;
      default: return 4'd7;
    endcase
  endfunction

  function automatic logic [3:0] base_b(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd4;
      2'b01:   return 4'd3;
      2'b10:   return 4'd5;
      default: return 4'd9;
    endcase
  endfunction

  function automatic ratio_t scale(input logic [3:0] base, input logic [1:0] mul);
    return ratio_t'(base) << mul;
  endfunction

  function automatic ratio_t ratio_of(input logic [CODE_W-1:0] code, input bit tbl_b);
    return scale(tbl_b ? base_b(code[1:0]) : base_a(code[1:0]), code[3:2]);
  endfunction
endpackage

// File: rtl/oddiv_ratio_dec.sv
`timescale 1ns/1ps
module oddiv_ratio_dec
  import oddiv_pkg::*;
#(
  parameter bit TABLE_B = 1'b0
) (
  input  logic [CODE_W-1:0] code,
  output ratio_t            ratio,
  output ratio_t            half,
  output logic              odd
);
  logic [3:0] base;

  generate
    if (TABLE_B) begin : g_tbl_b
      assign base = base_b(code[1:0]);
    end else begin : g_tbl_a
      assign base = base_a(code[1:0]);
    end
  endgenerate

  assign ratio = scale(base, code[3:2]);
  assign half  = ratio >> 1;
  assign odd   = ratio[0];
endmodule

// File: rtl/oddiv_stop_sync.sv
`timescale 1ns/1ps
module oddiv_stop_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_n,
  output logic stop_req
);
  logic s0, s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b1;
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s0 <= stop_n;
      s1 <= s0;
      s2 <= s1;
    end
  end

  // two consecutive low samples after the metastability stage
  assign stop_req = ~s1 & ~s2;
endmodule

// File: rtl/oddiv_seq.sv
`timescale 1ns/1ps
module oddiv_seq
  import oddiv_pkg::*;
#(
  parameter ratio_t RST_RATIO = ratio_t'(6)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t ratio_in,
  input  ratio_t half_in,
  input  logic   odd_in,
  input  logic   inv_in,
  input  logic   halt_req,
  output ratio_t cnt_q,
  output ratio_t ratio_q,
  output logic   ph_q,
  output logic   run_q,
  output logic   odd_q,
  output logic   inv_q
);
  localparam ratio_t ONE = ratio_t'(1);

  ratio_t half_q;
  logic   last, fall_pt, stop_pt;

  assign last    = (cnt_q == ratio_q - ONE);
  assign fall_pt = (cnt_q == half_q - ONE);
  // the output falls at the end of the high phase, or at period end when inverted
  assign stop_pt = inv_q ? last : fall_pt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RST_RATIO;
      half_q  <= RST_RATIO >> 1;
      odd_q   <= RST_RATIO[0];
      inv_q   <= 1'b0;
      ph_q    <= 1'b0;
      run_q   <= 1'b0;
    end else if (!run_q) begin
      if (!halt_req) begin
        run_q   <= 1'b1;
        cnt_q   <= '0;
        ph_q    <= 1'b1;
        ratio_q <= ratio_in;
        half_q  <= half_in;
        odd_q   <= odd_in;
        inv_q   <= inv_in;
      end
    end else if (halt_req && stop_pt) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (last) begin
      cnt_q   <= '0;
      ph_q    <= 1'b1;
      ratio_q <= ratio_in;
      half_q  <= half_in;
      odd_q   <= odd_in;
      inv_q   <= inv_in;
    end else begin
      cnt_q <= cnt_q + ONE;
      ph_q  <= (cnt_q + ONE) < half_q;
    end
  end
endmodule

// File: rtl/oddiv_out_gen.sv
`timescale 1ns/1ps
module oddiv_out_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ph,
  input  logic odd,
  input  logic inv,
  input  logic run,
  output logic clk_out
);
  logic ph_n;

  // half-cycle stretch: copy of the phase taken on the falling edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ph_n <= 1'b0;
    else        ph_n <= ph;
  end

  assign clk_out = (ph | (odd & ph_n)) ^ (inv & run);
endmodule

// File: rtl/oddiv_top.sv
`timescale 1ns/1ps
module oddiv_top
  import oddiv_pkg::*;
#(
  parameter bit TABLE_B = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              invert,
  input  logic              enable,
  input  logic              stop_n,
  output logic              clk_out
);
  localparam ratio_t RST_RATIO = ratio_of(CODE_DEFAULT, TABLE_B);

  ratio_t ratio_d, half_d, cnt_q, ratio_q;
  logic   odd_d, stop_req, halt_req;
  logic   ph_q, run_q, odd_q, inv_q;

  oddiv_ratio_dec #(.TABLE_B(TABLE_B)) u_dec (
    .code  (div_code),
    .ratio (ratio_d),
    .half  (half_d),
    .odd   (odd_d)
  );

  oddiv_stop_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_n   (stop_n),
    .stop_req (stop_req)
  );

  assign halt_req = ~enable | stop_req;

  oddiv_seq #(.RST_RATIO(RST_RATIO)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ratio_in (ratio_d),
    .half_in  (half_d),
    .odd_in   (odd_d),
    .inv_in   (invert),
    .halt_req (halt_req),
    .cnt_q    (cnt_q),
    .ratio_q  (ratio_q),
    .ph_q     (ph_q),
    .run_q    (run_q),
    .odd_q    (odd_q),
    .inv_q    (inv_q)
  );

  oddiv_out_gen u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .ph      (ph_q),
    .odd     (odd_q),
    .inv     (inv_q),
    .run     (run_q),
    .clk_out (clk_out)
  );
endmodule

// File: rtl/oddiv_chk.sv
`timescale 1ns/1ps
module oddiv_chk
  import oddiv_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input ratio_t cnt,
  input ratio_t ratio,
  input logic   run,
  input logic   ph
);
  // R2: the period counter never reaches the loaded ratio
  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < ratio));

  // R2: every loaded ratio is at least two
  p_ratio_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ratio >= ratio_t'(2));

  // R5: the ratio changes only when a period begins
  p_ratio_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio != $past(ratio)) |-> (cnt == '0));

  // R7: a halted channel is parked with its phase low
  p_halt_parked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (cnt == '0 && !ph));

  // R8: a restart begins a full high phase at count zero
  p_restart_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (ph && cnt == '0));
endmodule

bind oddiv_top oddiv_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cnt   (cnt_q),
  .ratio (ratio_q),
  .run   (run_q),
  .ph    (ph_q)
);

// File: tb/tb_oddiv_top.sv
`timescale 1ns/1ps
module tb_oddiv_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] code = 4'b0101;
  logic       inv = 1'b0;
  logic       en = 1'b1;
  logic       stop_n = 1'b1;
  logic       out_a, out_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  oddiv_top #(.TABLE_B(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .div_code(code), .invert(inv),
    .enable(en), .stop_n(stop_n), .clk_out(out_a));

  oddiv_top #(.TABLE_B(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .div_code(code), .invert(inv),
    .enable(en), .stop_n(stop_n), .clk_out(out_b));

  // half-cycle run-length monitor, sampled 2 ns after every clock edge
  int   nsamp = 0;
  logic cur_val[2] = '{1'b0, 1'b0};
  int   cur_len[2] = '{0, 0};
  int   last_hi[2] = '{0, 0};
  int   last_lo[2] = '{0, 0};
  int   rises[2]   = '{0, 0};
  int   rise_at[2] = '{0, 0};

  always @(clk) begin
    #2;
    nsamp++;
    for (int i = 0; i < 2; i++) begin
      logic s;
      s = (i == 0) ? out_a : out_b;
      if (s == cur_val[i]) cur_len[i]++;
      else begin
        if (cur_val[i]) last_hi[i] = cur_len[i];
        else            last_lo[i] = cur_len[i];
        if (s) begin
          rises[i]++;
          rise_at[i] = nsamp;
        end
        cur_val[i] = s;
        cur_len[i] = 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int sel, input logic [3:0] c, input int n, input string tag);
    int r0;
    @(negedge clk);
    code = c;
    r0 = rises[sel];
    wait (rises[sel] >= r0 + 3);
    check(last_hi[sel] == n, {tag, " high run"}, last_hi[sel], n);
    check(last_lo[sel] == n, {tag, " low run"}, last_lo[sel], n);
  endtask

  // halted output: quiet and low, final pulse full width
  task automatic check_quiet(input int n, input string tag);
    int r0;
    repeat (4 * n + 8) @(negedge clk);
    r0 = rises[0];
    repeat (3 * n) @(negedge clk);
    check(rises[0] == r0, {tag, " no pulses while halted"}, rises[0] - r0, 0);
    check(out_a == 1'b0, {tag, " output held low"}, int'(out_a), 0);
    check(last_hi[0] == n, {tag, " final pulse full width"}, last_hi[0], n);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(out_a == 1'b0 && out_b == 1'b0, "R1 output low in reset", int'(out_a | out_b), 0);
    rst_n = 1'b1;
    check(rises[0] == 0, "R1 no pulse before start", rises[0], 0);
  endtask

  task automatic t_table_a();
    logic [3:0] cs[7] = '{4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0101, 4'b1010, 4'b1111};
    int ns[7] = '{2, 3, 5, 7, 6, 20, 56};
    for (int i = 0; i < 7; i++)
      measure(0, cs[i], ns[i], ns[i] % 2 == 1 ? "R4 table A odd" : "R2 table A");
  endtask

  task automatic t_table_b();
    logic [3:0] cs[6] = '{4'b0000, 4'b0001, 4'b0011, 4'b0110, 4'b1101, 4'b1111};
    int ns[6] = '{4, 3, 9, 10, 24, 72};
    for (int i = 0; i < 6; i++) measure(1, cs[i], ns[i], "R3 table B");
  endtask

  task automatic t_change();
    int r0;
    measure(0, 4'b0011, 7, "R5 pre-change");
    r0 = rises[0];
    wait (rises[0] == r0 + 1);
    @(negedge clk);
    code = 4'b0000;
    r0 = rises[0];
    wait (rises[0] == r0 + 1);
    check(last_hi[0] == 7, "R5 pulse under way keeps old width", last_hi[0], 7);
    check(last_lo[0] == 7, "R5 low phase keeps old width", last_lo[0], 7);
    wait (rises[0] == r0 + 2);
    check(last_hi[0] == 2, "R5 new ratio after period start", last_hi[0], 2);
  endtask

  task automatic t_stop();
    int r0, t0;
    measure(0, 4'b0010, 5, "R6 pre-stop");
    @(negedge clk) stop_n = 1'b0;
    @(negedge clk) stop_n = 1'b1;
    r0 = rises[0];
    repeat (20) @(negedge clk);
    check(rises[0] > r0, "R6 single low sample ignored", rises[0] - r0, 2);
    check(last_hi[0] == 5, "R6 width unchanged after glitch", last_hi[0], 5);
    @(negedge clk) stop_n = 1'b0;
    check_quiet(5, "R7 stop");
    @(negedge clk);
    stop_n = 1'b1;
    t0 = nsamp;
    r0 = rises[0];
    wait (rises[0] == r0 + 1);
    check(rise_at[0] - t0 == 6, "R6 restart after synchronizer delay", rise_at[0] - t0, 6);
    wait (rises[0] == r0 + 2);
    check(last_hi[0] == 5, "R8 first high phase full", last_hi[0], 5);
    check(last_lo[0] == 5, "R8 first low phase full", last_lo[0], 5);
  endtask

  task automatic t_enable();
    int r0, t0;
    @(negedge clk) en = 1'b0;
    check_quiet(5, "R7 disable");
    @(negedge clk);
    en = 1'b1;
    t0 = nsamp;
    r0 = rises[0];
    wait (rises[0] == r0 + 1);
    check(rise_at[0] - t0 == 2, "R8 restart rises at period start", rise_at[0] - t0, 2);
    wait (rises[0] == r0 + 2);
    check(last_hi[0] == 5, "R8 enable first pulse full", last_hi[0], 5);
  endtask

  task automatic t_invert();
    int r0, t0;
    @(negedge clk) inv = 1'b1;
    measure(0, 4'b0010, 5, "R9 inverted");
    @(negedge clk) en = 1'b0;
    check_quiet(5, "R9 inverted halt");
    @(negedge clk);
    en = 1'b1;
    t0 = nsamp;
    r0 = rises[0];
    wait (rises[0] == r0 + 1);
    check(rise_at[0] - t0 == 7, "R9 inverted restart begins low", rise_at[0] - t0, 7);
    @(negedge clk) inv = 1'b0;
    measure(0, 4'b0001, 3, "R9 back to normal");
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_table_a();
    t_table_b();
    t_change();
    t_stop();
    t_enable();
    t_invert();
    report();
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_tests, 0);
    report();
  end
endmodule